// File: doc/BRIEF.md
# Serial register-file front end for a real-time clock

This block lets an SPI master reach the register map of a real-time clock. The master holds chip select low and shifts in a command byte. The command byte picks a read or a write, picks RAM or register space, and carries a 5-bit address. One or more data bytes follow. An address field of all ones turns the transfer into a burst. In register space, a burst walks through the eight clock registers. In RAM space, it walks through all 31 scratch bytes. The RAM and the control register live inside the block. All other register addresses are forwarded to the timekeeping core over a parallel port: a combinational read address and data pair, and a one-cycle write strobe.

The serial lines are synchronised into the system clock, and their edges are detected there. The SPI clock therefore has to run well below the system clock. Bit 7 of the control register is a write-protect flag. While it is set, every write is refused except a write that lands on the control register itself. That exception covers both a single control write and the eighth byte of a clock burst write.

Top module: `spi_rtc_if`

## Requirements
- R1: SPI mode 3, MSB first. `din` is sampled on rising `sclk` edges. `dout` changes only after falling `sclk` edges, so it is stable across every rising edge while `doutOe` is high.
- R2: Command byte fields: bit 7 is the read flag (1 = read), bit 6 is the space select (1 = RAM, 0 = registers), and bits 5..1 are the address. Bit 0 must be 1. A command with bit 0 at 0 makes the rest of that transfer do nothing: no write and no output drive.
- R3: A single register write produces exactly one `tkWrEn` pulse, carrying the address and the byte. A single read returns `tkRdData` for that address. After the first data byte of a non-burst transfer, further written bytes are dropped and further read bytes are 00h.
- R4: `doutOe` is high only after a read command has been decoded and while `csN` is low. When it is low, `dout` is 0 and no read data leaves the block.
- R5: Command 3Fh (burst write) or BFh (burst read) moves eight bytes through register addresses 0 to 7 in ascending order: seconds, minutes, hours, date, month, weekday, year, control. Bytes after the eighth are dropped on writes and read as 00h.
- R6: The control register sits at register address 7 inside the block and is never forwarded to the core. It keeps only bit 7, and bits 6..0 read as zero.
- R7: While control bit 7 is 1, writes to RAM and to core registers are refused. A single write to the control register is still accepted.
- R8: The eighth byte of a clock burst write updates the control register even while write protect is set.
- R9: The RAM holds 31 bytes at RAM addresses 0 to 30. Write command = 40h | addr<<1 | 1, and read command = C0h | addr<<1 | 1.
- R10: A RAM burst (7Fh write, FFh read) steps through addresses 0 to 30 in order. A burst that stops early writes only the bytes that were fully shifted in.
- R11: Raising `csN` at any point aborts the transfer. A partial byte is discarded and never written, and the next transfer starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial lines are sampled with it |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from the master |
| dout | output | 1 | Serial data to the master |
| doutOe | output | 1 | Output enable for the external three-state driver on dout |
| tkRdAddr | output | 5 | Register address presented to the timekeeping core |
| tkRdData | input | 8 | Core register contents at tkRdAddr, combinational |
| tkWrEn | output | 1 | One-cycle write strobe to the core |
| tkWrAddr | output | 5 | Core register address for the write |
| tkWrData | output | 8 | Byte written to the core |

## Verification
Several behaviours are checked every cycle:
- A deselected device never drives and never writes.
- Each core write is a single-cycle pulse.
- A core write never targets the control address.
- A core write never happens while read data is being driven.

The remaining behaviours depend on whole transfers, so only the bench scenarios can show them:
- The byte order of the bursts.
- The write-protect exception on the eighth burst byte.
- The auto-increment and early stop of RAM bursts.
- Discarding partial bytes on abort.
- Rejecting commands with bit 0 at zero.

The bench shows these by comparing read-back data and core contents against its own model.

// File: rtl/spi_rtc_pkg.sv
package spi_rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;

  // Per-cycle command from the control FSM to the datapath
  typedef struct packed {
    logic              sample;  // shift bitIn into the receive register
    logic              bitIn;   // synchronised serial input
    logic              launch;  // move the next transmit bit onto dout
    logic              load;    // fetch a byte into the transmit register
    logic              blank;   // fetched byte is forced to zero
    logic              write;   // completed byte is to be stored
    logic              ram;     // target space: 1 = RAM
    logic [ADDR_W-1:0] addr;    // current target address
    logic              drive;   // output enable
    logic              clear;   // chip deselected
  } rtcStrobeT;
endpackage

// File: rtl/spi_rtc_ctrl.sv
module spi_rtc_ctrl
  import spi_rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_DEPTH   = 31,
  parameter int CLK_BURST   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic [BYTE_W-1:0] rxByte,
  output rtcStrobeT         st
);
  localparam int IDX_W   = $clog2(RAM_DEPTH + 1);
  localparam int BIT_W   = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, dinPipe;
  logic sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '1;
      dinPipe  <= '0;
      sclkPrev <= 1'b1;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      dinPipe  <= {dinPipe[SYNC_STAGES-2:0], din};
      sclkPrev <= sclkPipe[SYNC_STAGES-1];
    end
  end

  logic sclkS, active, rise, fall;
  assign sclkS  = sclkPipe[SYNC_STAGES-1];
  assign active = !csPipe[SYNC_STAGES-1];
  assign rise   = sclkS && !sclkPrev;
  assign fall   = !sclkS && sclkPrev;

  logic [BIT_W-1:0]  bitCnt;
  logic              inData, dead, isRead, isRam, isBurst, loadPend;
  logic [ADDR_W-1:0] ptr;
  logic [IDX_W-1:0]  idx, burstLen;
  logic              byteDone, cmdDone, dataDone, inRange, cmdBurst;

  always_comb begin
    if (!isBurst)   burstLen = IDX_W'(1);
    else if (isRam) burstLen = IDX_W'(RAM_DEPTH);
    else            burstLen = IDX_W'(CLK_BURST);
  end

  assign byteDone = rise && active && !dead && (bitCnt == LAST_BIT);
  assign cmdDone  = byteDone && !inData;
  assign dataDone = byteDone && inData;
  assign inRange  = idx < burstLen;
  assign cmdBurst = &rxByte[ADDR_W:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0; inData <= 1'b0; dead <= 1'b0; isRead <= 1'b0;
      isRam <= 1'b0; isBurst <= 1'b0; loadPend <= 1'b0;
      ptr <= '0; idx <= '0;
    end else if (!active) begin
      bitCnt   <= '0;
      inData   <= 1'b0;
      dead     <= 1'b0;
      isRead   <= 1'b0;
      loadPend <= 1'b0;
    end else begin
      if (rise && !dead) bitCnt <= bitCnt + 1'b1;
      if (cmdDone) begin
        if (!rxByte[0]) begin
          dead <= 1'b1;
        end else begin
          inData   <= 1'b1;
          isRead   <= rxByte[BYTE_W-1];
          isRam    <= rxByte[BYTE_W-2];
          isBurst  <= cmdBurst;
          ptr      <= cmdBurst ? '0 : rxByte[ADDR_W:1];
          idx      <= '0;
          loadPend <= rxByte[BYTE_W-1];
        end
      end
      if (dataDone && !isRead && inRange) begin
        ptr <= ptr + 1'b1;
        idx <= idx + 1'b1;
      end
      if (dataDone && isRead) loadPend <= 1'b1;
      if (loadPend) begin
        loadPend <= 1'b0;
        if (inRange) begin
          ptr <= ptr + 1'b1;
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    st.sample = rise && active && !dead;
    st.bitIn  = dinPipe[SYNC_STAGES-1];
    st.launch = fall && active && inData && isRead;
    st.load   = loadPend;
    st.blank  = !inRange;
    st.write  = dataDone && !isRead && inRange;
    st.ram    = isRam;
    st.addr   = ptr;
    st.drive  = active && inData && isRead;
    st.clear  = !active;
  end
endmodule

// File: rtl/spi_rtc_dpath.sv
module spi_rtc_dpath
  import spi_rtc_pkg::*;
#(
  parameter int RAM_DEPTH = 31,
  parameter int CTRL_ADDR = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobeT         st,
  output logic [BYTE_W-1:0] rxByte,
  output logic [ADDR_W-1:0] tkRdAddr,
  input  logic [BYTE_W-1:0] tkRdData,
  output logic              tkWrEn,
  output logic [ADDR_W-1:0] tkWrAddr,
  output logic [BYTE_W-1:0] tkWrData,
  output logic              dout,
  output logic              doutOe
);
  logic [BYTE_W-1:0] rxShift, txShift, ramRd, rdByte;
  logic [BYTE_W-1:0] ram [RAM_DEPTH];
  logic              wpBit, doutR, ctrlHit, ramHit, allow, ramWe;

  assign rxByte  = {rxShift[BYTE_W-2:0], st.bitIn};
  assign ctrlHit = !st.ram && (st.addr == ADDR_W'(CTRL_ADDR));
  assign ramHit  = st.addr < ADDR_W'(RAM_DEPTH);
  assign allow   = !wpBit || ctrlHit;
  assign ramWe   = st.write && st.ram && ramHit && allow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rxShift <= '0;
    else if (st.sample) rxShift <= rxByte;
  end

  for (genvar i = 0; i < RAM_DEPTH; i++) begin : g_row
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      ram[i] <= '0;
      else if (ramWe && st.addr == ADDR_W'(i))        ram[i] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      wpBit <= 1'b0;
    else if (st.write && ctrlHit)   wpBit <= rxByte[BYTE_W-1];
  end

  always_comb begin
    ramRd = '0;
    for (int k = 0; k < RAM_DEPTH; k++)
      if (st.addr == ADDR_W'(k)) ramRd = ram[k];
  end

  always_comb begin
    if (st.ram)       rdByte = ramRd;
    else if (ctrlHit) rdByte = {wpBit, {(BYTE_W-1){1'b0}}};
    else              rdByte = tkRdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      doutR   <= 1'b0;
    end else if (st.clear) begin
      txShift <= '0;
      doutR   <= 1'b0;
    end else if (st.load) begin
      txShift <= st.blank ? '0 : rdByte;
    end else if (st.launch) begin
      doutR   <= txShift[BYTE_W-1];
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign tkRdAddr = st.addr;
  assign tkWrEn   = st.write && !st.ram && !ctrlHit && allow;
  assign tkWrAddr = st.addr;
  assign tkWrData = rxByte;
  assign doutOe   = st.drive;
  assign dout     = st.drive && doutR;
endmodule

// File: rtl/spi_rtc_if.sv
module spi_rtc_if
  import spi_rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_DEPTH   = 31,
  parameter int CLK_BURST   = 8,
  parameter int CTRL_ADDR   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              doutOe,
  output logic [ADDR_W-1:0] tkRdAddr,
  input  logic [BYTE_W-1:0] tkRdData,
  output logic              tkWrEn,
  output logic [ADDR_W-1:0] tkWrAddr,
  output logic [BYTE_W-1:0] tkWrData
);
  rtcStrobeT         st;
  logic [BYTE_W-1:0] rxByte;

  spi_rtc_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .RAM_DEPTH(RAM_DEPTH), .CLK_BURST(CLK_BURST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .rxByte(rxByte), .st(st)
  );

  spi_rtc_dpath #(
    .RAM_DEPTH(RAM_DEPTH), .CTRL_ADDR(CTRL_ADDR)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .rxByte(rxByte),
    .tkRdAddr(tkRdAddr), .tkRdData(tkRdData),
    .tkWrEn(tkWrEn), .tkWrAddr(tkWrAddr), .tkWrData(tkWrData),
    .dout(dout), .doutOe(doutOe)
  );
endmodule

// File: rtl/spi_rtc_if_chk.sv
module spi_rtc_if_chk #(
  parameter int CTRL_ADDR = 7
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       doutOe,
  input logic       tkWrEn,
  input logic [4:0] tkWrAddr
);
  // R4: a deselected device stops driving once csN has been high for three samples
  assert_idle_no_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |-> !doutOe);

  // R11: a deselected device never writes to the core
  assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |-> !tkWrEn);

  // R3: every core write is a single-cycle pulse
  assert_write_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    tkWrEn |=> !tkWrEn);

  // R6: the control register is never forwarded to the core
  assert_ctrl_local_R6: assert property (@(posedge clk) disable iff (!rstN)
    tkWrEn |-> (tkWrAddr != 5'(CTRL_ADDR)));

  // R4: writes and output drive never overlap
  assert_write_not_reading_R4: assert property (@(posedge clk) disable iff (!rstN)
    tkWrEn |-> !doutOe);
endmodule

bind spi_rtc_if spi_rtc_if_chk #(.CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .doutOe(doutOe),
  .tkWrEn(tkWrEn), .tkWrAddr(tkWrAddr)
);

// File: tb/spi_rtc_if_bench.sv
module spi_rtc_if_bench;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b1, din = 1'b0;
  logic dout, doutOe, tkWrEn;
  logic [4:0] tkRdAddr, tkWrAddr;
  logic [7:0] tkRdData, tkWrData;

  always #4 clk = ~clk;

  spi_rtc_if u_spi_rtc_if (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .dout(dout), .doutOe(doutOe), .tkRdAddr(tkRdAddr), .tkRdData(tkRdData),
    .tkWrEn(tkWrEn), .tkWrAddr(tkWrAddr), .tkWrData(tkWrData)
  );

  // Timekeeping core model: plain register file
  logic [7:0] tkMem [32];
  int wrCount = 0;
  assign tkRdData = tkMem[tkRdAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) tkMem[i] <= 8'h00;
    end else if (tkWrEn) begin
      tkMem[tkWrAddr] <= tkWrData;
      wrCount <= wrCount + 1;
    end
  end

  int tests = 0, fails = 0, unstable = 0;
  bit oeSeen, done = 0;
  logic [7:0] txB [40];
  logic [7:0] rxB [40];
  logic [7:0] expTk [32];
  logic [7:0] expRam [31];
  logic expWp;

  function automatic logic [7:0] cmdW(input bit ram, input int a);
    return {1'b0, ram, a[4:0], 1'b1};
  endfunction
  function automatic logic [7:0] cmdR(input bit ram, input int a);
    return {1'b1, ram, a[4:0], 1'b1};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // cut < 0 : full transfer; otherwise csN rises after cut bits
  task automatic xfer(input logic [7:0] cmd, input int n, input int cut);
    logic s1, s2, v;
    oeSeen = 0;
    @(negedge clk); csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < 8 * (n + 1); b++) begin
      if (cut >= 0 && b == cut) break;
      v = (b < 8) ? cmd[7 - b % 8] : txB[b / 8 - 1][7 - b % 8];
      sclk = 1'b0; din = v;
      repeat (HALF) @(negedge clk);
      s1 = dout; oeSeen |= doutOe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      s2 = dout;
      if (doutOe && s1 !== s2) unstable++;
      if (b >= 8) rxB[b / 8 - 1][7 - b % 8] = s1;
    end
    sclk = 1'b1; csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr1(input bit ram, input int a, input logic [7:0] d);
    txB[0] = d; xfer(cmdW(ram, a), 1, -1);
    if (ram) begin if (!expWp) expRam[a] = d; end
    else if (a == 7) expWp = d[7];
    else if (!expWp) expTk[a] = d;
  endtask

  task automatic rd1(input bit ram, input int a, input string req);
    logic [7:0] e;
    xfer(cmdR(ram, a), 1, -1);
    e = ram ? expRam[a] : (a == 7 ? {expWp, 7'h00} : expTk[a]);
    chk(req, rxB[0], e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int c, a;
    logic [7:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) expTk[i] = 8'h00;
    for (int i = 0; i < 31; i++) expRam[i] = 8'h00;
    expWp = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 reset oe", {7'h0, doutOe}, 8'h00);
    chk("R4 reset dout", {7'h0, dout}, 8'h00);

    // R3 single write, one pulse, read back, extra bytes
    c = wrCount;
    wr1(0, 3, 8'hA5);
    chk("R3 core write", tkMem[3], 8'hA5);
    chk("R3 one pulse", 8'(wrCount - c), 8'h01);
    txB[0] = 8'h00; txB[1] = 8'h00;
    xfer(cmdR(0, 3), 2, -1);
    chk("R3 single read", rxB[0], 8'hA5);
    chk("R3 extra read byte", rxB[1], 8'h00);
    chk("R4 oe on read", {7'h0, oeSeen}, 8'h01);
    chk("R1 dout stable", 8'(unstable), 8'h00);
    txB[0] = 8'h11; txB[1] = 8'h22;
    xfer(cmdW(0, 9), 2, -1); expTk[9] = 8'h11;
    chk("R3 extra write dropped", tkMem[9], 8'h11);
    chk("R3 next addr untouched", tkMem[10], 8'h00);

    // R2 bit 0 clear
    txB[0] = 8'h77; xfer(8'h08, 1, -1);
    chk("R2 bad cmd write", tkMem[4], 8'h00);
    xfer(8'h86, 1, -1);
    chk("R2 bad cmd no drive", {7'h0, oeSeen}, 8'h00);
    txB[0] = 8'h00; xfer(cmdW(0, 3), 1, -1); // wrote 00 to 3 via ok cmd
    expTk[3] = 8'h00;
    txB[0] = 8'h5C; xfer(8'h06, 1, -1);
    chk("R2 ram/addr of bad cmd ignored", tkMem[3], 8'h00);

    // R11 aborts
    xfer(cmdW(0, 5), 1, 4);
    txB[0] = 8'hFF; xfer(cmdW(0, 5), 1, 12);
    chk("R11 partial byte discarded", tkMem[5], 8'h00);
    wr1(0, 5, 8'h3C);
    chk("R11 fresh transfer", tkMem[5], 8'h3C);

    // R5/R6 clock burst write then read
    for (int i = 0; i < 7; i++) txB[i] = 8'(8'h31 + 8'(i * 17));
    txB[7] = 8'h00; txB[8] = 8'hEE;
    xfer(8'h3F, 9, -1);
    for (int i = 0; i < 7; i++) expTk[i] = txB[i];
    for (int i = 0; i < 7; i++) chk("R5 burst write order", tkMem[i], expTk[i]);
    chk("R5 ninth byte dropped", tkMem[8], 8'h00);
    wr1(0, 7, 8'h7F);
    rd1(0, 7, "R6 ctrl low bits zero");
    for (int i = 0; i < 9; i++) txB[i] = 8'h00;
    xfer(8'hBF, 9, -1);
    for (int i = 0; i < 7; i++) chk("R5 burst read order", rxB[i], expTk[i]);
    chk("R5 burst ctrl byte", rxB[7], 8'h00);
    chk("R5 ninth read zero", rxB[8], 8'h00);
    chk("R1 burst dout stable", 8'(unstable), 8'h00);

    // R7 write protect
    wr1(0, 7, 8'h80);
    rd1(0, 7, "R6 wp readback");
    wr1(0, 2, 8'h99);
    chk("R7 core write refused", tkMem[2], expTk[2]);
    wr1(1, 4, 8'h99);
    rd1(1, 4, "R7 ram write refused");
    wr1(0, 7, 8'h00);
    rd1(0, 7, "R7 ctrl write under wp");
    wr1(0, 7, 8'h80);

    // R8 burst clears protection with last byte
    for (int i = 0; i < 7; i++) txB[i] = 8'hC3;
    txB[7] = 8'h00;
    xfer(8'h3F, 8, -1); expWp = 0;
    chk("R8 burst data refused", tkMem[0], expTk[0]);
    rd1(0, 7, "R8 burst ctrl applied");

    // R9 RAM single ends
    wr1(1, 0, 8'h12); rd1(1, 0, "R9 ram addr 0");
    wr1(1, 30, 8'hE7); rd1(1, 30, "R9 ram addr 30");

    // R10 RAM bursts
    for (int i = 0; i < 31; i++) begin txB[i] = 8'($urandom); expRam[i] = txB[i]; end
    xfer(8'h7F, 31, -1);
    for (int i = 0; i < 31; i++) txB[i] = 8'h00;
    xfer(8'hFF, 31, -1);
    for (int i = 0; i < 31; i++) chk("R10 ram burst", rxB[i], expRam[i]);
    for (int i = 0; i < 6; i++) txB[i] = 8'(8'hA0 + 8'(i));
    xfer(8'h7F, 6, 8 * 6 + 3);
    for (int i = 0; i < 5; i++) expRam[i] = txB[i];
    for (int i = 0; i < 6; i++) rd1(1, i, "R10 early stop");

    // Random single accesses
    for (int it = 0; it < 40; it++) begin
      bit r;
      r = 1'($urandom);
      a = int'($urandom % 31);
      if (!r && a == 7) a = 9;
      d = 8'($urandom);
      wr1(r, a, d);
      rd1(r, a, r ? "R9 random ram" : "R3 random reg");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule